// File: doc/BRIEF.md
# Serial Memory Command Sequencer

This block interprets the traffic of one chip-select frame from a serial memory port. A physical shifter, outside the block, converts the serial lines into whole bytes and announces the frame edges. The sequencer treats the first byte of the frame as the command and gives every later byte of that frame its role: address, write data, status data, or nothing. It drives a single-port synchronous 2048x8 byte store and asks an external protection unit whether each write is allowed.

Six commands exist. Two set and clear the write-enable flag. One returns a status byte and one hands a status byte to the protection unit. Two move memory data in bursts of any length from a two-byte starting address. Memory writes commit byte by byte as the bytes arrive, with no page buffer and no busy state. Reads keep the next byte fetched before the shifter asks for it, so a burst has no gaps. The address wraps inside the 11-bit space.

Top module: `serial_mem_sequencer`

## Requirements
- R1: The first byte of a frame selects the command: 0x06 sets write enable, 0x04 clears it, 0x05 reads status, 0x01 writes status, 0x03 reads memory, 0x02 writes memory.
- R2: Set and clear enable take effect when their byte is received. A status read returns `prot_status` with bit 1 replaced by the write-enable flag.
- R3: Only the first byte of a frame is decoded. Any other first byte makes the rest of the frame idle: no `tx_ready`, no `mem_we` or `mem_re`, no `sr_we`, and no flag change.
- R4: Memory commands take two address bytes, most significant first. The low 11 bits of those 16 bits are the start address and the top 5 bits are ignored.
- R5: In a write burst, each data byte drives `mem_we` in the cycle it is received, but only when the flag is set and `prot_mem_ok` is high. The address then advances by one, whether the byte was stored or not.
- R6: In a read burst, `tx_byte` carries the byte at the current address while `tx_ready` is high. Each `tx_take` advances the address. Received bytes are ignored. `mem_rdata` is valid one cycle after `mem_re`.
- R7: The address wraps from 0x7FF to 0x000 in both read and write bursts.
- R8: Status write accepts one byte and pulses `sr_we` with that byte only when the flag is set and `prot_sr_ok` is high. Later bytes in the frame are ignored.
- R9: At frame end the flag is cleared if the frame's command was status write or memory write, even if no data byte arrived. Any other command leaves the flag unchanged.
- R10: After reset the flag is clear and `tx_ready`, `mem_we`, `mem_re` and `sr_we` are low.
- R11: In a read burst, after a `tx_take` the next byte is presented on `tx_ready` within three clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_start | input | 1 | One-cycle pulse at chip-select assertion |
| frm_end | input | 1 | One-cycle pulse at chip-select release |
| rx_valid | input | 1 | A whole received byte is on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| tx_take | input | 1 | Shifter latches `tx_byte` for the next output slot |
| tx_ready | output | 1 | `tx_byte` holds a byte to be shifted out |
| tx_byte | output | 8 | Byte offered for output |
| mem_addr | output | ADDR_W | Byte store address, also seen by the protection unit |
| mem_re | output | 1 | Byte store read strobe |
| mem_we | output | 1 | Byte store write strobe |
| mem_wdata | output | 8 | Byte store write data |
| mem_rdata | input | 8 | Byte store read data, one cycle after `mem_re` |
| prot_mem_ok | input | 1 | Protection unit allows a write at `mem_addr` |
| prot_sr_ok | input | 1 | Protection unit allows a status write |
| prot_status | input | 8 | Status bits held by the protection unit |
| sr_we | output | 1 | Status write strobe to the protection unit |
| sr_wdata | output | 8 | Status write data |

## Verification
If the phase or the captured command is wrong, a byte goes to the wrong place in the next received byte. A data byte then shows up as a spurious `mem_we` or `sr_we`, or a later byte acts as a command. A stale write-enable flag shows in the very next status read, at bit 1. An address counter that is off shows only on readback, so each write pattern is followed by a read burst across the wrap point. A slow prefetch shows as `tx_ready` still low more than three cycles after a take.

// File: rtl/seq_pkg.sv
package seq_pkg;

   localparam logic [7:0] OPC_WREN  = 8'h06;
   localparam logic [7:0] OPC_WRDI  = 8'h04;
   localparam logic [7:0] OPC_RDSR  = 8'h05;
   localparam logic [7:0] OPC_WRSR  = 8'h01;
   localparam logic [7:0] OPC_READ  = 8'h03;
   localparam logic [7:0] OPC_WRITE = 8'h02;

   typedef enum logic [2:0] {
      CMD_NONE, CMD_WREN, CMD_WRDI, CMD_RDSR, CMD_WRSR, CMD_READ, CMD_WRITE
   } seq_cmd_e;

   typedef enum logic [2:0] {
      PH_OFF, PH_OP, PH_ADDR, PH_WDATA, PH_RDATA, PH_SRR, PH_SRW, PH_SKIP
   } seq_phase_e;

endpackage

// File: rtl/seq_opdec.sv
module seq_opdec
   import seq_pkg::*;
(
   input  logic [7:0] op_byte,
   output seq_cmd_e   op_cmd
);
   always_comb begin
      unique case (op_byte)
         OPC_WREN:  op_cmd = CMD_WREN;
         OPC_WRDI:  op_cmd = CMD_WRDI;
         OPC_RDSR:  op_cmd = CMD_RDSR;
         OPC_WRSR:  op_cmd = CMD_WRSR;
         OPC_READ:  op_cmd = CMD_READ;
         OPC_WRITE: op_cmd = CMD_WRITE;
         default:   op_cmd = CMD_NONE;
      endcase
   end
endmodule

// File: rtl/seq_addr_ctr.sv
module seq_addr_ctr #(
   parameter int ADDR_W     = 11,
   parameter int ADDR_BYTES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              shift_en,
   input  logic [7:0]        shift_byte,
   input  logic              inc,
   output logic [ADDR_W-1:0] addr,
   output logic              last
);
   localparam int CAT_W = ADDR_W + 8;
   localparam int CNT_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

   logic [ADDR_W-1:0] addr_q;
   logic [CAT_W-1:0]  cat;
   logic [7:0]        cat_top_unused;

   assign cat            = {addr_q, shift_byte};
   assign cat_top_unused = cat[CAT_W-1:ADDR_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        addr_q <= '0;
      else if (shift_en) addr_q <= cat[ADDR_W-1:0];
      else if (inc)      addr_q <= addr_q + 1'b1;
   end

   assign addr = addr_q;

   generate
      if (ADDR_BYTES == 1) begin : g_single
         logic clr_unused;
         assign clr_unused = clr;
         assign last       = shift_en;
      end else begin : g_multi
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cnt_q <= '0;
            else if (clr)      cnt_q <= '0;
            else if (shift_en) cnt_q <= cnt_q + 1'b1;
         end
         assign last = shift_en && (cnt_q == CNT_W'(ADDR_BYTES - 1));
      end
   endgenerate
endmodule

// File: rtl/seq_rd_pipe.sv
module seq_rd_pipe (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       flush,
   input  logic       active,
   input  logic       take,
   input  logic [7:0] rdata,
   output logic       re,
   output logic       valid,
   output logic [7:0] data
);
   logic       pend_q;
   logic       valid_q;
   logic [7:0] data_q;

   assign re = active && !valid_q && !pend_q && !flush;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         valid_q <= 1'b0;
         data_q  <= '0;
      end else if (flush) begin
         pend_q  <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         pend_q <= re;
         if (pend_q) begin
            data_q  <= rdata;
            valid_q <= 1'b1;
         end else if (take) begin
            valid_q <= 1'b0;
         end
      end
   end

   assign valid = valid_q;
   assign data  = data_q;
endmodule

// File: rtl/serial_mem_sequencer.sv
module serial_mem_sequencer
   import seq_pkg::*;
#(
   parameter int ADDR_W     = 11,
   parameter int ADDR_BYTES = 2,
   parameter int WEL_POS    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_start,
   input  logic              frm_end,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              tx_take,
   output logic              tx_ready,
   output logic [7:0]        tx_byte,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_re,
   output logic              mem_we,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   input  logic              prot_mem_ok,
   input  logic              prot_sr_ok,
   input  logic [7:0]        prot_status,
   output logic              sr_we,
   output logic [7:0]        sr_wdata
);
   generate
      if (ADDR_W < 1 || ADDR_W > 8 * ADDR_BYTES) begin : g_bad_addr
         $error("ADDR_W must fit inside ADDR_BYTES bytes");
      end
      if (ADDR_BYTES < 1) begin : g_bad_bytes
         $error("ADDR_BYTES must be at least 1");
      end
      if (WEL_POS < 0 || WEL_POS > 7) begin : g_bad_wel
         $error("WEL_POS must index a bit of the status byte");
      end
   endgenerate

   seq_phase_e phase_q;
   seq_cmd_e   cmd_q;
   seq_cmd_e   dec_cmd;
   logic       wel_q;
   logic       addr_last;
   logic       addr_shift;
   logic       addr_inc;
   logic       rd_valid;
   logic [7:0] rd_data;
   logic [7:0] stat_byte;
   logic       rd_active;
   logic       rd_take;

   seq_opdec u_dec (
      .op_byte (rx_byte),
      .op_cmd  (dec_cmd)
   );

   assign addr_shift = (phase_q == PH_ADDR) && rx_valid;
   assign rd_active  = (phase_q == PH_RDATA);
   assign rd_take    = rd_active && tx_take && rd_valid;
   assign addr_inc   = ((phase_q == PH_WDATA) && rx_valid) || rd_take;

   seq_addr_ctr #(
      .ADDR_W     (ADDR_W),
      .ADDR_BYTES (ADDR_BYTES)
   ) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (frm_start),
      .shift_en   (addr_shift),
      .shift_byte (rx_byte),
      .inc        (addr_inc),
      .addr       (mem_addr),
      .last       (addr_last)
   );

   seq_rd_pipe u_rd (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (frm_start || frm_end),
      .active (rd_active),
      .take   (rd_take),
      .rdata  (mem_rdata),
      .re     (mem_re),
      .valid  (rd_valid),
      .data   (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_OFF;
         cmd_q   <= CMD_NONE;
         wel_q   <= 1'b0;
      end else if (frm_end) begin
         phase_q <= PH_OFF;
         cmd_q   <= CMD_NONE;
         if (cmd_q == CMD_WRSR || cmd_q == CMD_WRITE) wel_q <= 1'b0;
      end else if (frm_start) begin
         phase_q <= PH_OP;
         cmd_q   <= CMD_NONE;
      end else begin
         unique case (phase_q)
            PH_OP: if (rx_valid) begin
               cmd_q <= dec_cmd;
               unique case (dec_cmd)
                  CMD_WREN:  begin wel_q <= 1'b1; phase_q <= PH_SKIP; end
                  CMD_WRDI:  begin wel_q <= 1'b0; phase_q <= PH_SKIP; end
                  CMD_RDSR:  phase_q <= PH_SRR;
                  CMD_WRSR:  phase_q <= PH_SRW;
                  CMD_READ,
                  CMD_WRITE: phase_q <= PH_ADDR;
                  default:   phase_q <= PH_SKIP;
               endcase
            end
            PH_ADDR: if (addr_last)
               phase_q <= (cmd_q == CMD_READ) ? PH_RDATA : PH_WDATA;
            PH_SRR:  if (tx_take)  phase_q <= PH_SKIP;
            PH_SRW:  if (rx_valid) phase_q <= PH_SKIP;
            default: phase_q <= phase_q;
         endcase
      end
   end

   always_comb begin
      stat_byte          = prot_status;
      stat_byte[WEL_POS] = wel_q;
   end

   assign mem_we    = (phase_q == PH_WDATA) && rx_valid && wel_q && prot_mem_ok;
   assign mem_wdata = rx_byte;
   assign sr_we     = (phase_q == PH_SRW) && rx_valid && wel_q && prot_sr_ok;
   assign sr_wdata  = rx_byte;
   assign tx_ready  = (phase_q == PH_SRR) || (rd_active && rd_valid);
   assign tx_byte   = (phase_q == PH_SRR) ? stat_byte : rd_data;
endmodule

// File: rtl/seq_checker.sv
module seq_checker
   import seq_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frm_start,
   input logic              frm_end,
   input logic              tx_take,
   input logic              tx_ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_re,
   input logic              mem_we,
   input logic              sr_we,
   input logic              prot_mem_ok,
   input logic              prot_sr_ok,
   input logic              wel,
   input seq_phase_e        phase,
   input seq_cmd_e          cmd
);
   assert_we_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (wel && prot_mem_ok));

   assert_sr_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sr_we |-> (wel && prot_sr_ok));

   assert_wel_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_end && (cmd == CMD_WRSR || cmd == CMD_WRITE)) |=> !wel);

   assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

   assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SKIP || phase == PH_OFF) |-> !(tx_ready || mem_we || mem_re || sr_we));

   assert_read_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> !mem_we);

   assert_prefetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_take && tx_ready && phase == PH_RDATA && !frm_end && !frm_start)
      ##1 (!frm_end && !frm_start) ##1 (!frm_end && !frm_start) |=> tx_ready);
endmodule

bind serial_mem_sequencer seq_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frm_start   (frm_start),
   .frm_end     (frm_end),
   .tx_take     (tx_take),
   .tx_ready    (tx_ready),
   .mem_addr    (mem_addr),
   .mem_re      (mem_re),
   .mem_we      (mem_we),
   .sr_we       (sr_we),
   .prot_mem_ok (prot_mem_ok),
   .prot_sr_ok  (prot_sr_ok),
   .wel         (wel_q),
   .phase       (phase_q),
   .cmd         (cmd_q)
);

// File: tb/sim_serial_mem_sequencer.sv
module sim_serial_mem_sequencer;
   localparam int AW = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frm_start = 1'b0, frm_end = 1'b0, rx_valid = 1'b0, tx_take = 1'b0;
   logic [7:0]    rx_byte = '0;
   logic          tx_ready, mem_re, mem_we, sr_we;
   logic [7:0]    tx_byte, mem_wdata, sr_wdata;
   logic [7:0]    mem_rdata;
   logic [AW-1:0] mem_addr;
   logic          prot_mem_ok, prot_sr_ok;
   logic [7:0]    prot_status;

   logic       lock_on = 1'b0;
   logic       sr_ok   = 1'b1;
   logic [7:0] sr_model = 8'h00;
   logic [7:0] store [2048];
   int         we_cnt = 0, sr_cnt = 0;
   int         n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   assign prot_mem_ok = !(lock_on && mem_addr >= 11'h600);
   assign prot_sr_ok  = sr_ok;
   assign prot_status = {sr_model[7], 3'b000, sr_model[3:2], 2'b00};

   always @(posedge clk) begin
      if (mem_we) begin store[mem_addr] <= mem_wdata; we_cnt <= we_cnt + 1; end
      if (mem_re) mem_rdata <= store[mem_addr];
      if (sr_we) begin sr_model <= sr_wdata; sr_cnt <= sr_cnt + 1; end
   end

   serial_mem_sequencer u0 (
      .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_end(frm_end),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_take(tx_take),
      .tx_ready(tx_ready), .tx_byte(tx_byte), .mem_addr(mem_addr),
      .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .prot_mem_ok(prot_mem_ok), .prot_sr_ok(prot_sr_ok),
      .prot_status(prot_status), .sr_we(sr_we), .sr_wdata(sr_wdata)
   );

   // {lock, wren, expect, data, addr16}
   localparam logic [33:0] VEC [6] = '{
      {1'b0, 1'b1, 8'hA5, 8'hA5, 16'h0010},
      {1'b0, 1'b1, 8'h3C, 8'h3C, 16'hF812},
      {1'b0, 1'b0, 8'hA5, 8'hFF, 16'h0010},
      {1'b1, 1'b1, 8'h00, 8'h77, 16'h0700},
      {1'b1, 1'b1, 8'h11, 8'h11, 16'h05FF},
      {1'b0, 1'b1, 8'h9E, 8'h9E, 16'h07FF}
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic f_begin();
      @(negedge clk); frm_start = 1'b1;
      @(negedge clk); frm_start = 1'b0;
   endtask

   task automatic f_end();
      @(negedge clk); frm_end = 1'b1;
      @(negedge clk); frm_end = 1'b0;
      @(negedge clk);
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk); rx_valid = 1'b1; rx_byte = b;
      @(negedge clk); rx_valid = 1'b0;
   endtask

   task automatic take(output logic [7:0] b, output int waited);
      waited = 0;
      while (!tx_ready && waited < 50) begin @(negedge clk); waited++; end
      b = tx_byte;
      tx_take = 1'b1;
      @(negedge clk); tx_take = 1'b0;
   endtask

   task automatic one_cmd(input logic [7:0] op);
      f_begin(); send(op); f_end();
   endtask

   task automatic rdsr(output logic [7:0] v);
      int w;
      f_begin(); send(8'h05); take(v, w); f_end();
   endtask

   task automatic wr1(input logic [15:0] a, input logic [7:0] d);
      f_begin(); send(8'h02); send(a[15:8]); send(a[7:0]); send(d); f_end();
   endtask

   task automatic rd1(input logic [15:0] a, output logic [7:0] d);
      int w;
      f_begin(); send(8'h03); send(a[15:8]); send(a[7:0]); take(d, w); f_end();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      int         w, we0;
      for (int i = 0; i < 2048; i++) store[i] = 8'h00;

      // R10: reset state
      repeat (3) @(negedge clk);
      chk(tx_ready == 1'b0, "R10 tx_ready after reset", tx_ready, 0);
      chk(mem_we == 1'b0 && sr_we == 1'b0, "R10 strobes after reset", mem_we, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_re == 1'b0, "R10 mem_re after reset", mem_re, 0);
      rdsr(v);
      chk(v == 8'h00, "R10 R2 status after reset", v, 8'h00);

      // R1 R5 R6 R4: vector table
      for (int i = 0; i < 6; i++) begin
         lock_on = VEC[i][33];
         if (VEC[i][32]) one_cmd(8'h06);
         wr1(VEC[i][15:0], VEC[i][23:16]);
         rd1(VEC[i][15:0], v);
         chk(v == VEC[i][31:24], $sformatf("R5 R6 vector %0d", i), v, VEC[i][31:24]);
      end
      lock_on = 1'b0;

      // R4: top five address bits ignored
      rd1(16'hA012, v);
      chk(v == 8'h3C, "R4 high address bits ignored", v, 8'h3C);

      // R2: enable / disable reported at bit 1
      one_cmd(8'h06); rdsr(v);
      chk(v == 8'h02, "R2 flag set", v, 8'h02);
      rdsr(v);
      chk(v == 8'h02, "R9 flag kept after status read", v, 8'h02);
      rd1(16'h0010, v); rdsr(v);
      chk(v == 8'h02, "R9 flag kept after memory read", v, 8'h02);
      one_cmd(8'h04); rdsr(v);
      chk(v == 8'h00, "R2 flag cleared", v, 8'h00);

      // R9: write frame with address only clears flag
      one_cmd(8'h06);
      f_begin(); send(8'h02); send(8'h00); send(8'h20); f_end();
      rdsr(v);
      chk(v == 8'h00, "R9 flag cleared by data-less write", v, 8'h00);

      // R8: status write, extra byte ignored
      one_cmd(8'h06);
      f_begin(); send(8'h01); send(8'h8C); send(8'h00); f_end();
      rdsr(v);
      chk(v == 8'h8C, "R8 status written once", v, 8'h8C);
      chk(sr_cnt == 1, "R8 single status strobe", sr_cnt, 1);
      sr_ok = 1'b0; one_cmd(8'h06);
      f_begin(); send(8'h01); send(8'h00); f_end();
      rdsr(v);
      chk(v == 8'h8C, "R8 blocked by protection", v, 8'h8C);
      sr_ok = 1'b1;
      f_begin(); send(8'h01); send(8'h00); f_end();
      rdsr(v);
      chk(v == 8'h8C, "R8 blocked without flag", v, 8'h8C);
      one_cmd(8'h06);
      f_begin(); send(8'h01); send(8'h00); f_end();
      rdsr(v);
      chk(v == 8'h00, "R8 status restored", v, 8'h00);

      // R3: undefined op-code then a valid one in the same frame
      we0 = we_cnt;
      f_begin(); send(8'hFF); send(8'h06); send(8'h02);
      @(negedge clk);
      chk(tx_ready == 1'b0, "R3 no output after bad op-code", tx_ready, 0);
      f_end();
      rdsr(v);
      chk(v == 8'h00, "R3 later byte not decoded", v, 8'h00);
      one_cmd(8'h06);
      f_begin(); send(8'h06); send(8'h02); send(8'h00); send(8'h20); send(8'h55); f_end();
      chk(we_cnt == we0, "R3 no write after enable frame", we_cnt, we0);
      rd1(16'h0020, v);
      chk(v == 8'h00, "R3 byte 0x020 untouched", v, 8'h00);
      one_cmd(8'h04);

      // R7 R5: write burst across the top
      one_cmd(8'h06);
      f_begin(); send(8'h02); send(8'h07); send(8'hFE);
      send(8'h01); send(8'h02); send(8'h03); send(8'h04); f_end();
      // R7 R6 R11: read burst across the top, SI traffic ignored
      f_begin(); send(8'h03); send(8'h07); send(8'hFE);
      for (int k = 0; k < 4; k++) begin
         take(v, w);
         chk(v == 8'(k + 1), $sformatf("R7 R6 burst byte %0d", k), v, k + 1);
         if (k > 0) chk(w <= 3, "R11 next byte latency", w, 3);
         send(8'h06);
      end
      f_end();
      chk(store[11'h7FF] == 8'h02 && store[11'h000] == 8'h03, "R7 wrap stored",
          store[11'h000], 8'h03);
      rdsr(v);
      chk(v == 8'h00, "R6 bytes during read ignored", v, 8'h00);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule